// File: doc/BRIEF.md
# GPIO Port Register Bank

A memory-mapped general-purpose I/O port of up to 32 pins, reached through a simple 32-bit register bus with separate read and write strobes. Per pin, software controls an output level, a direction, a hardware blink mode and an input polarity. The block drives the pad output values and output enables. It samples the pad inputs through a two-flop synchronizer, and it returns the inputs with the polarity applied. The same polarity-adjusted input vector goes out to a neighbouring interrupt unit.

Any output pin can hand its level over to a shared, free-running blink generator. The generator toggles with equal high and low times of `BLINK_HALF` clock cycles. Software sets a pin's data-out bit low before it enables blinking. Reads are registered, so `rdata` holds the selected register one clock after `rd_en`.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset the data-out, blink and polarity registers read 0, the direction register reads all ones, `pad_oe` is 0 and `pad_out` is 0.
- R2: Writes at byte offsets 0x00 (data-out), 0x04 (direction), 0x08 (blink enable) and 0x0C (polarity) store `wdata`. A read at the same offset returns the stored value on `rdata` in the cycle after the `rd_en` cycle.
- R3: A direction bit of 1 makes the pin an input (`pad_oe` bit 0). A 0 makes it an output (`pad_oe` bit 1). The change is visible in the cycle after the write.
- R4: A pin whose blink bit is 0 drives `pad_out` from its data-out bit.
- R5: A pin whose blink bit is 1 drives `pad_out` from the shared blink phase and ignores its data-out bit. The phase toggles every `BLINK_HALF` cycles, so all blinking pins carry the same level.
- R6: A read at offset 0x10 returns the synchronized pad input XOR the polarity register. A pad change reaches that value after two clock edges, and not after one.
- R7: `in_level` carries the same polarity-adjusted vector that offset 0x10 returns, and it tracks polarity writes from the next cycle.
- R8: Writes at offset 0x10 change no register.
- R9: Reads at offsets 0x14 and above, and reads at addresses with bits [1:0] non-zero, return 0. Writes there change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| pad_in | input | NUM_PINS | Raw pad inputs |
| pad_out | output | NUM_PINS | Pad output values |
| pad_oe | output | NUM_PINS | Pad output enables |
| in_level | output | NUM_PINS | Polarity-adjusted inputs to the interrupt unit |

## Verification
The assertions assume that `addr` and `wdata` are stable and known whenever a strobe is high. They also assume that `pad_in` is a known level at each clock edge, so the two-cycle synchronizer delay can be checked exactly. The bench drives every input at the falling edge and holds it across the next rising edge. It changes pad inputs only at falling edges, and it never raises both strobes with conflicting intent. Blink timing is measured from the distance between observed `pad_out` transitions, not from an absolute start cycle.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int MAX_PINS = 32;

    typedef enum logic [2:0] {
        SLOT_DOUT  = 3'd0,
        SLOT_DIR   = 3'd1,
        SLOT_BLINK = 3'd2,
        SLOT_POL   = 3'd3,
        SLOT_DIN   = 3'd4
    } reg_slot_e;

    typedef struct packed {
        logic [MAX_PINS-1:0] dout;
        logic [MAX_PINS-1:0] dir;
        logic [MAX_PINS-1:0] blink;
        logic [MAX_PINS-1:0] pol;
        logic [31:0]         rdata;
    } bank_t;
endpackage

// File: rtl/gpio_blink_timer.sv
module gpio_blink_timer #(
    parameter int HALF_CYCLES = 10_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic phase
);
    localparam int CNT_W = (HALF_CYCLES > 2) ? $clog2(HALF_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_CYCLES - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             phase;
    } tmr_t;

    tmr_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == LAST) begin
            st_d.cnt   = '0;
            st_d.phase = ~st_q.phase;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign phase = st_q.phase;

    // R5
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST);

    // R5
    phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt != LAST) |=> $stable(phase));
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_in,
    output logic [WIDTH-1:0] sync_out
);
    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] stable;
    } sync_t;

    sync_t st_q, st_d;

    always_comb begin
        st_d.meta   = raw_in;
        st_d.stable = st_q.meta;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_out = st_q.stable;

    logic [1:0] age_q;
    always_ff @(posedge clk) begin
        if (!rst_n)          age_q <= '0;
        else if (age_q != 2) age_q <= age_q + 1'b1;
    end

    // R6
    two_stage_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2) |-> (sync_out == $past(raw_in, 2)));
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_pkg::*;
#(
    parameter int NUM_PINS   = 32,
    parameter int ADDR_W     = 8,
    parameter int BLINK_HALF = 10_000_000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [31:0]         wdata,
    output logic [31:0]         rdata,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic [NUM_PINS-1:0] in_level
);
    localparam int IDX_W = ADDR_W - 2;
    localparam logic [MAX_PINS-1:0] PIN_MASK =
        (NUM_PINS >= MAX_PINS) ? '1 : MAX_PINS'((64'd1 << NUM_PINS) - 1);

    bank_t st_q, st_d;

    logic                blink_phase;
    logic [NUM_PINS-1:0] pad_sync;
    logic [MAX_PINS-1:0] in_wide;
    logic [IDX_W-1:0]    word_idx;
    logic                hit;
    reg_slot_e           slot;

    gpio_blink_timer #(.HALF_CYCLES(BLINK_HALF)) u_blink (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (blink_phase)
    );

    gpio_in_sync #(.WIDTH(NUM_PINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_in   (pad_in),
        .sync_out (pad_sync)
    );

    always_comb begin
        in_wide = '0;
        in_wide[NUM_PINS-1:0] = pad_sync;
        in_wide = (in_wide ^ st_q.pol) & PIN_MASK;
    end

    assign word_idx = addr[ADDR_W-1:2];
    assign hit      = (addr[1:0] == 2'b00) && (word_idx <= IDX_W'(4));
    assign slot     = reg_slot_e'(word_idx[2:0]);

    always_comb begin
        st_d = st_q;
        if (wr_en && hit) begin
            unique case (slot)
                SLOT_DOUT:  st_d.dout  = wdata & PIN_MASK;
                SLOT_DIR:   st_d.dir   = wdata & PIN_MASK;
                SLOT_BLINK: st_d.blink = wdata & PIN_MASK;
                SLOT_POL:   st_d.pol   = wdata & PIN_MASK;
                default:    ;
            endcase
        end
        if (rd_en) begin
            st_d.rdata = '0;
            if (hit) begin
                unique case (slot)
                    SLOT_DOUT:  st_d.rdata = st_q.dout;
                    SLOT_DIR:   st_d.rdata = st_q.dir;
                    SLOT_BLINK: st_d.rdata = st_q.blink;
                    SLOT_POL:   st_d.rdata = st_q.pol;
                    SLOT_DIN:   st_d.rdata = in_wide;
                    default:    st_d.rdata = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.dir   <= PIN_MASK;
        end else begin
            st_q <= st_d;
        end
    end

    logic [MAX_PINS-1:0] drive;
    always_comb begin
        drive = (st_q.dout & ~st_q.blink) | (st_q.blink & {MAX_PINS{blink_phase}});
    end

    assign rdata    = st_q.rdata;
    assign pad_out  = drive[NUM_PINS-1:0];
    assign pad_oe   = ~st_q.dir[NUM_PINS-1:0];
    assign in_level = in_wide[NUM_PINS-1:0];

    // R3
    dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(8'h04)) |=> (pad_oe == ~$past(wdata[NUM_PINS-1:0])));

    // R8
    din_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(8'h10)) |=> $stable(pad_oe));

    // R9
    unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !hit) |=> (rdata == 32'd0));

    // R6
    din_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_W'(8'h10)) |=> (rdata[NUM_PINS-1:0] == $past(in_level)));
endmodule

// File: tb/tb_gpio_port_regs.sv
module tb_gpio_port_regs;
    localparam int N    = 32;
    localparam int AW   = 8;
    localparam int HALF = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [N-1:0]  pad_in = '0;
    logic [N-1:0]  pad_out, pad_oe, in_level;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    gpio_port_regs #(.NUM_PINS(N), .ADDR_W(AW), .BLINK_HALF(HALF)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .in_level(in_level)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 pad_oe", pad_oe, 32'h0);
        chk("R1 pad_out", pad_out, 32'h0);
        rd(8'h00, v); chk("R1 dout", v, 32'h0);
        rd(8'h04, v); chk("R1 dir", v, 32'hFFFF_FFFF);
        rd(8'h08, v); chk("R1 blink", v, 32'h0);
        rd(8'h0C, v); chk("R1 pol", v, 32'h0);
    endtask

    task automatic t_regs_rw();
        logic [31:0] v;
        wr(8'h00, 32'h1234_5678); rd(8'h00, v); chk("R2 dout", v, 32'h1234_5678);
        wr(8'h0C, 32'hCAFE_0001); rd(8'h0C, v); chk("R2 pol", v, 32'hCAFE_0001);
        wr(8'h08, 32'h0000_0000); rd(8'h08, v); chk("R2 blink", v, 32'h0);
        wr(8'h04, 32'h0F0F_0F0F); rd(8'h04, v); chk("R2 dir", v, 32'h0F0F_0F0F);
        wr(8'h0C, 32'h0);
    endtask

    task automatic t_direction();
        wr(8'h04, 32'hFFFF_0000);
        chk("R3 oe after dir", pad_oe, 32'h0000_FFFF);
        wr(8'h04, 32'h0000_0001);
        chk("R3 oe pin0 input", pad_oe, 32'hFFFF_FFFE);
    endtask

    task automatic t_output();
        wr(8'h08, 32'h0);
        wr(8'h00, 32'hA5A5_3C3C);
        chk("R4 pad_out follows dout", pad_out, 32'hA5A5_3C3C);
        wr(8'h00, 32'h5A5A_C3C3);
        chk("R4 pad_out second pattern", pad_out, 32'h5A5A_C3C3);
    endtask

    task automatic t_blink();
        logic prev;
        int   last_edge;
        int   edges;
        wr(8'h00, 32'h0000_0002);
        wr(8'h08, 32'h0000_0003);
        prev = pad_out[1]; last_edge = -1; edges = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (pad_out[0] !== pad_out[1]) chk("R5 shared phase", {31'd0, pad_out[0]}, {31'd0, pad_out[1]});
            if (pad_out[1] !== prev) begin
                if (last_edge >= 0) chk("R5 half period", i - last_edge, HALF);
                last_edge = i; edges++;
            end
            prev = pad_out[1];
        end
        chk("R5 toggles seen", (edges >= 4) ? 32'd1 : 32'd0, 32'd1);
        chk("R5 others follow dout", pad_out[31:2], 30'h0);
        wr(8'h08, 32'h0);
        chk("R4 after blink off", pad_out, 32'h0000_0002);
    endtask

    task automatic t_input();
        logic [31:0] v;
        wr(8'h0C, 32'h0);
        @(negedge clk); pad_in = 32'hDEAD_BEEF;
        @(negedge clk);
        chk("R6 not after one edge", in_level, 32'h0);
        @(negedge clk);
        chk("R7 in_level after two edges", in_level, 32'hDEAD_BEEF);
        rd(8'h10, v); chk("R6 din read", v, 32'hDEAD_BEEF);
        wr(8'h0C, 32'hFFFF_0000);
        chk("R7 in_level with polarity", in_level, 32'h2152_BEEF);
        rd(8'h10, v); chk("R6 din with polarity", v, 32'h2152_BEEF);
        wr(8'h0C, 32'h0);
    endtask

    task automatic t_ignored();
        logic [31:0] v;
        wr(8'h00, 32'h0000_00F0);
        wr(8'h04, 32'h0000_FFFF);
        wr(8'h10, 32'hFFFF_FFFF);
        chk("R8 oe unchanged", pad_oe, 32'hFFFF_0000);
        chk("R8 out unchanged", pad_out, 32'h0000_00F0);
        rd(8'h0C, v); chk("R8 pol unchanged", v, 32'h0);
        rd(8'h10, v); chk("R8 din unchanged", v, 32'hDEAD_BEEF);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        rd(8'h14, v); chk("R9 read 0x14", v, 32'h0);
        rd(8'hFC, v); chk("R9 read 0xFC", v, 32'h0);
        rd(8'h05, v); chk("R9 misaligned read", v, 32'h0);
        wr(8'h18, 32'hFFFF_FFFF);
        wr(8'h01, 32'hFFFF_FFFF);
        chk("R9 out unchanged", pad_out, 32'h0000_00F0);
        chk("R9 oe unchanged", pad_oe, 32'hFFFF_0000);
        rd(8'h00, v); chk("R9 dout unchanged", v, 32'h0000_00F0);
        rd(8'h08, v); chk("R9 blink unchanged", v, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs_rw();
        t_direction();
        t_output();
        t_blink();
        t_input();
        t_ignored();
        t_unmapped();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule